// File: doc/BRIEF.md
# Dual Down-Counting Timer with Shared Prescaler

This block is a bus peripheral that holds two 32-bit down-counting timers behind one 16-bit prescaler. The prescaler counts down from its reload value to zero, and each time it wraps it produces a one-clock tick. So the tick period is the reload value plus one clocks. Each enabled timer steps down once per tick. When a timer steps from zero it underflows. The timer then either reloads itself from its own reload register or falls to all ones. If its interrupt enable is set, it also drives a one-clock pulse on its own interrupt line.

Software reaches the block over a plain APB slave port. Each transfer completes in its setup and access cycles, with no wait states. The block has no error response. A read-only configuration word tells software how many timers are present and which interrupt number the first one uses. Timer `i` signals interrupt number `BASE_IRQ + i`, and the bus-side wiring maps `irq_pulse[i]` onto that number.

Top module: `dual_tick_timer`

## Requirements
- R1: After reset, scaler reload and scaler value are 0xFFFF, every timer counter and reload register reads 0xFFFFFFFF, and every control register reads 0.
- R2: Offset 0x08 reads 0x100 | (BASE_IRQ << 3) | NTIMERS, and writes to it change nothing.
- R3: Offset 0x00 returns the live scaler value. When no reload write occurs, it drops by one each clock and goes from 0 back to the reload value. Writes to 0x00 are ignored.
- R4: A write to offset 0x04 stores the low 16 bits as the new reload and also loads them into the scaler value in the same cycle. This restarts the period, and no tick is issued in that cycle.
- R5: An enabled timer drops its counter by one on each tick. A disabled timer keeps its counter unchanged.
- R6: An enabled timer whose counter holds N underflows on tick N+1. On underflow the counter becomes all ones, or becomes the reload value when the restart bit is set.
- R7: In the control word, bit 0 is enable, bit 1 is restart and bit 3 is interrupt enable, and only these bits are kept. Bit 2 set in a write copies the reload value into the counter, and bit 2 always reads 0.
- R8: On an underflow with interrupt enable set, `irq_pulse[i]` of that timer is high for exactly the following clock. With interrupt enable clear, there is no pulse. No other timer's line moves.
- R9: Timer i (from 0) sits at base 0x10 * (i + 1), with counter at +0x0, reload at +0x4 and control at +0x8. Reads of unmapped or misaligned offsets return 0.
- R10: A write to a timer's counter or control register replaces that timer's count step in the same cycle. The step is not applied afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | Clock |
| presetn | input | 1 | Synchronous reset, active low |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when high |
| paddr | input | 8 | Byte offset |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase |
| irq_pulse | output | NTIMERS | One-clock underflow pulse per timer |

## Verification
The assertions assume that only one bus write is in progress at a time. They also assume that a write is complete once `psel`, `penable` and `pwrite` are all high for one cycle. The bench meets both assumptions because its bus tasks never overlap and always run the setup phase, then the access phase, then idle. Cycle-exact expectations for the scaler value and for the first underflow are computed from a bench cycle counter. The bench logs the cycle in which each write lands, so no expectation depends on an unknown prescaler phase. Periodic checks measure the spacing between two pulses, which does not depend on phase.

// File: rtl/dtt_pkg.sv
// Shared constants and types for the dual tick timer.
// Assumes word-aligned 8-bit byte offsets and a 32-bit data bus.
package dtt_pkg;
    localparam int DATA_W = 32;
    localparam int SCL_W  = 16;
    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] OFS_SCL_VAL = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_SCL_RLD = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_CONFIG  = 8'h08;

    localparam logic [1:0] SUB_CNT = 2'd0;
    localparam logic [1:0] SUB_RLD = 2'd1;
    localparam logic [1:0] SUB_CTL = 2'd2;

    localparam int CTL_EN = 0;
    localparam int CTL_RS = 1;
    localparam int CTL_LD = 2;
    localparam int CTL_IE = 3;

    typedef struct packed {
        logic ie;
        logic rs;
        logic en;
    } tctl_t;

    function automatic logic [DATA_W-1:0] ctl_to_word(tctl_t c);
        logic [DATA_W-1:0] w;
        w         = '0;
        w[CTL_EN] = c.en;
        w[CTL_RS] = c.rs;
        w[CTL_IE] = c.ie;
        return w;
    endfunction

    function automatic tctl_t nib_to_ctl(logic [3:0] n);
        tctl_t c;
        c.en = n[CTL_EN];
        c.rs = n[CTL_RS];
        c.ie = n[CTL_IE];
        return c;
    endfunction
endpackage

// File: rtl/dtt_regif.sv
// Register decode for the dual tick timer: turns APB accesses into
// per-register write strobes and multiplexes read data.
// Assumes zero-wait-state APB; a write lands in the access cycle.
module dtt_regif
    import dtt_pkg::*;
#(
    parameter int NTIMERS  = 2,
    parameter int BASE_IRQ = 8
) (
    input  logic                            psel,
    input  logic                            penable,
    input  logic                            pwrite,
    input  logic [ADDR_W-1:0]               paddr,
    input  logic [SCL_W-1:0]                scl_val,
    input  logic [SCL_W-1:0]                scl_rld,
    input  logic [NTIMERS-1:0][DATA_W-1:0]  t_cnt,
    input  logic [NTIMERS-1:0][DATA_W-1:0]  t_rld,
    input  logic [NTIMERS-1:0][DATA_W-1:0]  t_ctlw,
    output logic                            scl_rld_wr,
    output logic [NTIMERS-1:0]              cnt_wr,
    output logic [NTIMERS-1:0]              rld_wr,
    output logic [NTIMERS-1:0]              ctl_wr,
    output logic [DATA_W-1:0]               prdata
);
    localparam logic [DATA_W-1:0] CFG_WORD =
        DATA_W'(32'h100 | (BASE_IRQ << 3) | NTIMERS);

    logic              wr_en;
    logic              aligned;
    logic [1:0]        sub;
    logic [NTIMERS-1:0] t_hit;

    assign wr_en   = psel & penable & pwrite;
    assign aligned = (paddr[1:0] == 2'b00);
    assign sub     = paddr[3:2];

    assign scl_rld_wr = wr_en & (paddr == OFS_SCL_RLD);

    // Per-timer slot match and write strobes.
    for (genvar i = 0; i < NTIMERS; i++) begin : g_dec
        assign t_hit[i]  = aligned & (paddr[7:4] == 4'(i + 1));
        assign cnt_wr[i] = wr_en & t_hit[i] & (sub == SUB_CNT);
        assign rld_wr[i] = wr_en & t_hit[i] & (sub == SUB_RLD);
        assign ctl_wr[i] = wr_en & t_hit[i] & (sub == SUB_CTL);
    end

    // Read data multiplexer; unmapped offsets return zero.
    always_comb begin
        prdata = '0;
        if (paddr == OFS_SCL_VAL)      prdata = DATA_W'(scl_val);
        else if (paddr == OFS_SCL_RLD) prdata = DATA_W'(scl_rld);
        else if (paddr == OFS_CONFIG)  prdata = CFG_WORD;
        for (int i = 0; i < NTIMERS; i++) begin
            if (t_hit[i]) begin
                case (sub)
                    SUB_CNT: prdata = t_cnt[i];
                    SUB_RLD: prdata = t_rld[i];
                    SUB_CTL: prdata = t_ctlw[i];
                    default: prdata = '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/dtt_prescaler.sv
// Shared prescaler: counts down from its reload to zero and emits a
// one-clock tick on each wrap. A reload write restarts the period.
// Assumes the reload write strobe is a single-cycle pulse.
module dtt_prescaler
    import dtt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rld_wr,
    input  logic [SCL_W-1:0] rld_data,
    output logic [SCL_W-1:0] val,
    output logic [SCL_W-1:0] rld,
    output logic             tick
);
    // A tick fires on the zero state unless a restart happens now.
    assign tick = (val == '0) && !rld_wr;

    // Reload register and down-counting scaler value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val <= '1;
            rld <= '1;
        end else if (rld_wr) begin
            val <= rld_data;
            rld <= rld_data;
        end else if (tick) begin
            val <= rld;
        end else begin
            val <= val - 1'b1;
        end
    end
endmodule

// File: rtl/dtt_timer.sv
// One down-counting timer: steps on prescaler ticks while enabled,
// reloads or falls to all ones on underflow, pulses its interrupt.
// Assumes at most one of its write strobes is high in a cycle.
module dtt_timer
    import dtt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              cnt_wr,
    input  logic              rld_wr,
    input  logic              ctl_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] cnt,
    output logic [DATA_W-1:0] rld,
    output tctl_t             ctl,
    output logic              busy,
    output logic              irq
);
    logic step;
    logic at_zero;

    assign busy    = cnt_wr | ctl_wr;
    assign step    = tick & ctl.en & !busy;
    assign at_zero = (cnt == '0);

    // Counter: bus writes first, then load request, then count step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '1;
        end else if (cnt_wr) begin
            cnt <= wdata;
        end else if (ctl_wr && wdata[CTL_LD]) begin
            cnt <= rld;
        end else if (step) begin
            if (at_zero) cnt <= ctl.rs ? rld : '1;
            else         cnt <= cnt - 1'b1;
        end
    end

    // Reload value register.
    always_ff @(posedge clk) begin
        if (!rst_n)      rld <= '1;
        else if (rld_wr) rld <= wdata;
    end

    // Stored control bits; the load bit is never kept.
    always_ff @(posedge clk) begin
        if (!rst_n)      ctl <= '0;
        else if (ctl_wr) ctl <= nib_to_ctl(wdata[3:0]);
    end

    // Interrupt pulse in the clock after an enabled underflow.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= step & at_zero & ctl.ie;
    end
endmodule

// File: rtl/dual_tick_timer.sv
// Top of the dual tick timer: APB register decode, one shared
// prescaler and NTIMERS down-counting timers with pulse interrupts.
// Assumes NTIMERS in 1..7 and BASE_IRQ in 0..31 (config field widths).
module dual_tick_timer
    import dtt_pkg::*;
#(
    parameter int NTIMERS  = 2,
    parameter int BASE_IRQ = 8
) (
    input  logic               pclk,
    input  logic               presetn,
    input  logic               psel,
    input  logic               penable,
    input  logic               pwrite,
    input  logic [7:0]         paddr,
    input  logic [31:0]        pwdata,
    output logic [31:0]        prdata,
    output logic [NTIMERS-1:0] irq_pulse
);
    logic                           scl_tick;
    logic [SCL_W-1:0]               scl_val;
    logic [SCL_W-1:0]               scl_rld;
    logic [SCL_W-1:0]               scl_wdata;
    logic                           scl_rld_wr;
    logic [NTIMERS-1:0]             cnt_wr, rld_wr, ctl_wr;
    logic [NTIMERS-1:0][DATA_W-1:0] t_cnt, t_rld, t_ctlw;
    logic [NTIMERS-1:0]             t_en, t_rs, t_ie, t_busy;

    assign scl_wdata = pwdata[SCL_W-1:0];

    dtt_regif #(.NTIMERS(NTIMERS), .BASE_IRQ(BASE_IRQ)) u_regif (
        .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
        .scl_val(scl_val), .scl_rld(scl_rld),
        .t_cnt(t_cnt), .t_rld(t_rld), .t_ctlw(t_ctlw),
        .scl_rld_wr(scl_rld_wr), .cnt_wr(cnt_wr), .rld_wr(rld_wr),
        .ctl_wr(ctl_wr), .prdata(prdata)
    );

    dtt_prescaler u_scl (
        .clk(pclk), .rst_n(presetn), .rld_wr(scl_rld_wr),
        .rld_data(scl_wdata), .val(scl_val), .rld(scl_rld), .tick(scl_tick)
    );

    for (genvar i = 0; i < NTIMERS; i++) begin : g_tmr
        tctl_t ctl_i;
        dtt_timer u_tmr (
            .clk(pclk), .rst_n(presetn), .tick(scl_tick),
            .cnt_wr(cnt_wr[i]), .rld_wr(rld_wr[i]), .ctl_wr(ctl_wr[i]),
            .wdata(pwdata), .cnt(t_cnt[i]), .rld(t_rld[i]), .ctl(ctl_i),
            .busy(t_busy[i]), .irq(irq_pulse[i])
        );
        assign t_ctlw[i] = ctl_to_word(ctl_i);
        assign t_en[i]   = ctl_i.en;
        assign t_rs[i]   = ctl_i.rs;
        assign t_ie[i]   = ctl_i.ie;
    end
endmodule

// File: rtl/dtt_checker.sv
// Temporal checks for the dual tick timer, bound into the top.
// Assumes write strobes are single-cycle, as APB access phases are.
module dtt_checker #(
    parameter int NTIMERS = 2,
    parameter int SCL_W   = 16,
    parameter int DATA_W  = 32
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           tick,
    input logic [SCL_W-1:0]               scl_val,
    input logic [SCL_W-1:0]               scl_rld,
    input logic [SCL_W-1:0]               scl_wdata,
    input logic                           scl_rld_wr,
    input logic [NTIMERS-1:0][DATA_W-1:0] cnt,
    input logic [NTIMERS-1:0][DATA_W-1:0] rld,
    input logic [NTIMERS-1:0]             en,
    input logic [NTIMERS-1:0]             rs,
    input logic [NTIMERS-1:0]             ie,
    input logic [NTIMERS-1:0]             busy,
    input logic [NTIMERS-1:0]             irq
);
    p_scaler_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !scl_rld_wr) |=> (scl_val == $past(scl_val) - 1'b1));

    p_scaler_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (scl_val == $past(scl_rld)));

    p_reload_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        scl_rld_wr |=> (scl_val == $past(scl_wdata)) && (scl_rld == $past(scl_wdata)));

    for (genvar i = 0; i < NTIMERS; i++) begin : g_chk
        p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (!en[i] && !busy[i]) |=> (cnt[i] == $past(cnt[i])));

        p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (tick && en[i] && !busy[i] && cnt[i] != '0)
            |=> (cnt[i] == $past(cnt[i]) - 1'b1));

        p_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (tick && en[i] && !busy[i] && cnt[i] == '0)
            |=> (cnt[i] == ($past(rs[i]) ? $past(rld[i]) : {DATA_W{1'b1}})));

        p_irq_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
            irq[i] |-> ($past(tick) && $past(en[i]) && $past(ie[i])
                        && $past(cnt[i]) == '0 && !$past(busy[i])));

        // R10: a write cycle never counts as a step
        p_write_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
            busy[i] |=> !irq[i]);
    end
endmodule

bind dual_tick_timer dtt_checker #(
    .NTIMERS(NTIMERS), .SCL_W(dtt_pkg::SCL_W), .DATA_W(dtt_pkg::DATA_W)
) u_chk (
    .clk(pclk), .rst_n(presetn), .tick(scl_tick),
    .scl_val(scl_val), .scl_rld(scl_rld), .scl_wdata(scl_wdata),
    .scl_rld_wr(scl_rld_wr), .cnt(t_cnt), .rld(t_rld),
    .en(t_en), .rs(t_rs), .ie(t_ie), .busy(t_busy), .irq(irq_pulse)
);

// File: tb/tb_dual_tick_timer.sv
module tb_dual_tick_timer;
    localparam int NT   = 2;
    localparam int BASE = 8;

    logic          pclk = 1'b0;
    logic          presetn = 1'b0;
    logic          psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [7:0]    paddr = '0;
    logic [31:0]   pwdata = '0;
    logic [31:0]   prdata;
    logic [NT-1:0] irq_pulse;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int wr_cyc = 0;
    int rd_cyc = 0;

    dual_tick_timer #(.NTIMERS(NT), .BASE_IRQ(BASE)) dut (
        .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .irq_pulse(irq_pulse)
    );

    always #5 pclk = ~pclk;
    always @(posedge pclk) cyc <= cyc + 1;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // wr_cyc: posedge count after the edge where the write lands
    task automatic apb_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge pclk);
        psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
        @(negedge pclk);
        penable = 1'b1;
        wr_cyc = cyc + 1;
        @(negedge pclk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic apb_rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge pclk);
        psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
        @(negedge pclk);
        penable = 1'b1;
        #1;
        d = prdata;
        rd_cyc = cyc;
        @(negedge pclk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic t_reset_values();
        logic [31:0] d;
        chk("R1 irq idle", 32'(irq_pulse), 32'h0);
        apb_rd(8'h04, d); chk("R1 scaler reload", d, 32'h0000_FFFF);
        apb_rd(8'h10, d); chk("R1 t0 counter", d, 32'hFFFF_FFFF);
        apb_rd(8'h14, d); chk("R1 t0 reload", d, 32'hFFFF_FFFF);
        apb_rd(8'h18, d); chk("R1 t0 ctrl", d, 32'h0);
        apb_rd(8'h20, d); chk("R1 t1 counter", d, 32'hFFFF_FFFF);
        apb_rd(8'h28, d); chk("R1 t1 ctrl", d, 32'h0);
        apb_rd(8'h08, d); chk("R2 config", d, 32'h100 | (BASE << 3) | NT);
        apb_wr(8'h08, 32'h0);
        apb_rd(8'h08, d); chk("R2 config after write", d, 32'h100 | (BASE << 3) | NT);
        apb_rd(8'h30, d); chk("R9 unmapped slot", d, 32'h0);
        apb_rd(8'h0C, d); chk("R9 unmapped offset", d, 32'h0);
        apb_rd(8'h12, d); chk("R9 misaligned", d, 32'h0);
    endtask

    task automatic t_scaler_count();
        logic [31:0] v1, v2;
        int c1;
        apb_rd(8'h00, v1); c1 = rd_cyc;
        apb_rd(8'h00, v2);
        chk("R3 scaler counts down", v2, v1 - 32'(rd_cyc - c1));
        apb_wr(8'h00, 32'h5);
        apb_rd(8'h00, v2);
        chk("R3 write to value ignored", v2, v1 - 32'(rd_cyc - c1));
    endtask

    task automatic t_scaler_restart();
        logic [31:0] d;
        int w;
        apb_wr(8'h04, 32'hABCD_03E8); w = wr_cyc;
        apb_rd(8'h00, d);
        chk("R4 restart value", d, 32'd1000 - 32'(rd_cyc - w));
        apb_rd(8'h04, d);
        chk("R4 reload keeps low 16 bits", d, 32'h0000_03E8);
    endtask

    task automatic t_load_bit();
        logic [31:0] d;
        apb_wr(8'h18, 32'h0);
        apb_wr(8'h14, 32'h0000_1234);
        apb_wr(8'h18, 32'h6);
        apb_rd(8'h10, d); chk("R7 load copies reload", d, 32'h0000_1234);
        apb_rd(8'h18, d); chk("R7 load bit reads 0", d, 32'h2);
        apb_wr(8'h18, 32'hFFFF_FFF0);
        apb_rd(8'h18, d); chk("R7 only bits 0,1,3 kept", d, 32'h0);
        repeat (20) @(negedge pclk);
        apb_rd(8'h10, d); chk("R5 disabled timer holds", d, 32'h0000_1234);
        apb_wr(8'h24, 32'h0000_0077);
        apb_rd(8'h14, d); chk("R9 t0 reload separate", d, 32'h0000_1234);
        apb_rd(8'h24, d); chk("R9 t1 reload at 0x24", d, 32'h0000_0077);
    endtask

    task automatic t_decrement();
        logic [31:0] d;
        int w;
        apb_wr(8'h04, 32'h0);
        apb_wr(8'h10, 32'd1000);
        apb_wr(8'h18, 32'h1); w = wr_cyc;
        repeat (7) @(negedge pclk);
        apb_rd(8'h10, d);
        // R10: the control-write edge is not a step
        chk("R5 R10 decrement per tick", d, 32'd1000 - 32'(rd_cyc - w));
        apb_wr(8'h18, 32'h0);
    endtask

    task automatic t_one_shot();
        logic [31:0] d;
        int w, seen;
        bit other;
        seen = -1; other = 0;
        apb_wr(8'h04, 32'h0);
        apb_wr(8'h20, 32'd5);
        apb_wr(8'h28, 32'h9); w = wr_cyc;
        for (int k = 0; k < 30 && seen < 0; k++) begin
            @(negedge pclk);
            if (irq_pulse[0]) other = 1;
            if (irq_pulse[1]) seen = cyc;
        end
        chk("R6 underflow after N+1 ticks", 32'(seen), 32'(w + 5 + 1));
        chk("R8 other line quiet", 32'(other), 32'h0);
        @(negedge pclk);
        chk("R8 pulse one clock", 32'(irq_pulse[1]), 32'h0);
        apb_rd(8'h20, d);
        chk("R6 falls to all ones", d, 32'hFFFF_FFFF - 32'(rd_cyc - (w + 6)));
        apb_wr(8'h28, 32'h0);
    endtask

    task automatic t_period(input int idx, input int s, input int r);
        int c1, n;
        bit other;
        other = 0; c1 = -1; n = 0;
        apb_wr(8'h18, 32'h0);
        apb_wr(8'h28, 32'h0);
        apb_wr(8'h04, 32'(s));
        apb_wr(8'(8'h14 + 8'h10 * idx), 32'(r));
        apb_wr(8'(8'h10 + 8'h10 * idx), 32'(r));
        apb_wr(8'(8'h18 + 8'h10 * idx), 32'hB);
        for (int k = 0; k < 2000 && n < 2; k++) begin
            @(negedge pclk);
            if (irq_pulse[1 - idx]) other = 1;
            if (irq_pulse[idx]) begin
                if (n == 0) c1 = cyc;
                else chk("R6 R8 auto-reload period", 32'(cyc - c1), 32'((s + 1) * (r + 1)));
                n++;
            end
        end
        chk("R8 pulses seen", 32'(n), 32'd2);
        chk("R8 only own line", 32'(other), 32'h0);
        apb_wr(8'(8'h18 + 8'h10 * idx), 32'h0);
    endtask

    task automatic t_no_ie();
        logic [31:0] d;
        bit any;
        any = 0;
        apb_wr(8'h04, 32'h0);
        apb_wr(8'h14, 32'd2);
        apb_wr(8'h18, 32'h3);
        for (int k = 0; k < 30; k++) begin
            @(negedge pclk);
            if (irq_pulse[0]) any = 1;
        end
        chk("R8 no pulse with ie clear", 32'(any), 32'h0);
        apb_rd(8'h10, d);
        chk("R6 restart keeps counter in reload range", 32'(d <= 32'd2), 32'h1);
        apb_wr(8'h18, 32'h0);
    endtask

    initial begin
        #(10 * 150000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge pclk);
        presetn = 1'b1;
        @(negedge pclk);
        t_reset_values();
        t_scaler_count();
        t_scaler_restart();
        t_load_bit();
        t_decrement();
        t_one_shot();
        t_period(0, 3, 4);
        t_period(1, 0, 2);
        t_no_ie();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule